// File: doc/BRIEF.md
# Phase-Offset Integer Clock Divider

This block divides a fast clock by an integer ratio from 1 to 16. After a synchronization pulse, it holds back its first output edge by a programmable number of fast-clock cycles. Several copies share the fast clock and one synchronization line. Each copy is given its own phase word, so their outputs are skewed from one another in steps of one fast-clock period. Each step is 360° divided by the ratio.

The divide ratio and the phase word are plain control inputs. The block reads them only on the first clock edge after the synchronization pulse goes low, so changing them in the middle of a run does nothing until the next pulse. The output stays high for ceil(N/2) fast cycles and low for floor(N/2) fast cycles. This puts odd ratios as close to half duty as whole fast cycles allow. A ratio of 1 sends the fast clock straight through.

Top module: `phase_clk_div`

## Requirements
- R1: During reset and afterwards, until the first synchronization pulse, `div_o` is low.
- R2: While `sync_i` is high the output is held low and the divider is idle. This applies even if the divider was running.
- R3: The load edge is the first rising clock edge at which `sync_i` is seen low after being high. With effective offset k, `div_o` first goes high on the (1+k)-th rising edge after the load edge. Two copies with offsets ka and kb therefore rise (kb−ka) fast cycles apart.
- R4: The ratio is N = `ratio_m1_i` + 1. Once the output is running, it repeats with a period of N fast cycles: high for ceil(N/2) cycles, then low for floor(N/2) cycles.
- R5: The effective offset is `phase_i` modulo N. A phase word equal to N gives the same output as a phase word of 0, and 15 with N = 9 acts as 6.
- R6: Odd ratios such as 5 and 9 give N distinct phases. Their high time is one fast cycle longer than their low time.
- R7: With N = 1, the output follows the fast clock from the first edge after the load edge on, and the phase word has no effect.
- R8: Changes to `ratio_m1_i` and `phase_i` made while the output is running do not alter the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_i | input | 1 | Synchronization pulse, active high; the falling side arms the divider |
| ratio_m1_i | input | RATIO_W (4) | Divide ratio minus one |
| phase_i | input | PHASE_W (4) | Phase offset in fast-clock cycles |
| div_o | output | 1 | Divided clock output |

## Verification
Every result is timed from the load edge. The output is low in the cycle after that edge. It first rises 1+k edges later and then follows a fixed N-cycle pattern. While the synchronization pulse is high, the output is low one edge after each sampled high. The bench turns each case into one expected level per fast cycle for two copies with different phase words. It queues these levels at the moment it drops the pulse, so the first item lines up with the load edge. A monitor samples each cycle a quarter period after the rising edge and again a quarter period after the falling edge, which also covers the pass-through case.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_COUNT = 2'd1,
    WS_RUN   = 2'd2
  } wait_st_e;
endpackage

// File: rtl/pcd_cfg_capture.sv
// Samples ratio and phase on the first edge that sees sync low after high.
module pcd_cfg_capture #(
  parameter int RATIO_W = 4,
  parameter int PHASE_W = 4,
  parameter int CNT_W   = RATIO_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sync_i,
  input  logic [RATIO_W-1:0] ratio_m1_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               load_o,
  output logic [PHASE_W-1:0] wait_o,
  output logic [CNT_W-1:0]   n_o,
  output logic [CNT_W-1:0]   hi_o,
  output logic               bypass_o
);
  localparam int SUM_W = CNT_W + PHASE_W;

  logic             sync_q;
  logic [CNT_W-1:0] n_in;
  logic [CNT_W-1:0] hi_in;
  logic [SUM_W-1:0] ph_ext;
  logic [SUM_W-1:0] n_ext;

  assign n_in   = CNT_W'(ratio_m1_i) + CNT_W'(1);
  assign hi_in  = CNT_W'((n_in + CNT_W'(1)) >> 1);
  assign ph_ext = SUM_W'(phase_i);
  assign n_ext  = SUM_W'(n_in);
  assign wait_o = PHASE_W'(ph_ext % n_ext);
  assign load_o = sync_q & ~sync_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q   <= 1'b0;
      n_o      <= CNT_W'(1);
      hi_o     <= CNT_W'(1);
      bypass_o <= 1'b0;
    end else begin
      sync_q <= sync_i;
      if (load_o) begin
        n_o      <= n_in;
        hi_o     <= hi_in;
        bypass_o <= (ratio_m1_i == '0);
      end
    end
  end
endmodule

// File: rtl/pcd_phase_wait.sv
// Counts down the phase offset after a load and flags the start cycle.
module pcd_phase_wait #(
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sync_i,
  input  logic               load_i,
  input  logic [PHASE_W-1:0] wait_i,
  output logic               start_o
);
  import pcd_pkg::*;

  wait_st_e           st_q;
  logic [PHASE_W-1:0] cnt_q;

  assign start_o = (st_q == WS_COUNT) && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i || sync_i) begin
      st_q  <= WS_IDLE;
      cnt_q <= '0;
    end else if (load_i) begin
      st_q  <= WS_COUNT;
      cnt_q <= wait_i;
    end else if (st_q == WS_COUNT) begin
      if (cnt_q == '0) st_q <= WS_RUN;
      else             cnt_q <= cnt_q - PHASE_W'(1);
    end
  end
endmodule

// File: rtl/pcd_wave_gen.sv
// Position counter over one output period; level is high for the first hi_i positions.
module pcd_wave_gen #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sync_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic             lvl_o,
  output logic             active_o
);
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] pos_nxt;

  assign pos_nxt = (pos_q == n_i - CNT_W'(1)) ? '0 : pos_q + CNT_W'(1);

  always_ff @(posedge clk_i) begin
    if (rst_i || sync_i) begin
      pos_q    <= '0;
      lvl_o    <= 1'b0;
      active_o <= 1'b0;
    end else if (start_i) begin
      pos_q    <= '0;
      lvl_o    <= 1'b1;
      active_o <= 1'b1;
    end else if (active_o) begin
      pos_q <= pos_nxt;
      lvl_o <= (pos_nxt < hi_i);
    end
  end
endmodule

// File: rtl/phase_clk_div.sv
module phase_clk_div #(
  parameter int RATIO_W = 4,
  parameter int PHASE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               sync_i,
  input  logic [RATIO_W-1:0] ratio_m1_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               div_o
);
  localparam int CNT_W = RATIO_W + 1;

  logic               load;
  logic [PHASE_W-1:0] wait_val;
  logic [CNT_W-1:0]   cfg_n;
  logic [CNT_W-1:0]   cfg_hi;
  logic               bypass;
  logic               start;
  logic               lvl_q;
  logic               active;

  pcd_cfg_capture #(
    .RATIO_W(RATIO_W), .PHASE_W(PHASE_W), .CNT_W(CNT_W)
  ) u_cfg (
    .clk_i(clk_i), .rst_i(rst_i), .sync_i(sync_i),
    .ratio_m1_i(ratio_m1_i), .phase_i(phase_i),
    .load_o(load), .wait_o(wait_val), .n_o(cfg_n), .hi_o(cfg_hi),
    .bypass_o(bypass)
  );

  pcd_phase_wait #(.PHASE_W(PHASE_W)) u_wait (
    .clk_i(clk_i), .rst_i(rst_i), .sync_i(sync_i),
    .load_i(load), .wait_i(wait_val), .start_o(start)
  );

  pcd_wave_gen #(.CNT_W(CNT_W)) u_wave (
    .clk_i(clk_i), .rst_i(rst_i), .sync_i(sync_i), .start_i(start),
    .n_i(cfg_n), .hi_i(cfg_hi), .lvl_o(lvl_q), .active_o(active)
  );

  // Ratio 1: the level stays high while running, so the fast clock passes.
  assign div_o = lvl_q & (bypass ? clk_i : 1'b1);
endmodule

// File: rtl/phase_clk_div_chk.sv
module phase_clk_div_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             sync_i,
  input logic             start_i,
  input logic             lvl_i,
  input logic             active_i,
  input logic [CNT_W-1:0] n_i,
  input logic [CNT_W-1:0] hi_i
);
  logic [CNT_W-1:0] hcnt_q;
  logic [CNT_W-1:0] lcnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hcnt_q <= '0;
      lcnt_q <= '0;
    end else begin
      hcnt_q <= (lvl_i && n_i > CNT_W'(1)) ? hcnt_q + CNT_W'(1) : '0;
      lcnt_q <= (active_i && !lvl_i) ? lcnt_q + CNT_W'(1) : '0;
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk_i) rst_i |=> (!lvl_i && !active_i)); // R1
  AST_SYNC_LOW: assert property (@(posedge clk_i) disable iff (rst_i) sync_i |=> !lvl_i); // R2
  AST_SYNC_IDLE: assert property (@(posedge clk_i) disable iff (rst_i) sync_i |=> !active_i); // R2
  AST_FIRST_EDGE: assert property (@(posedge clk_i) disable iff (rst_i)
    (start_i && !sync_i) |=> (lvl_i && active_i)); // R3
  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    (lvl_i && n_i > CNT_W'(1)) |-> (hcnt_q < hi_i)); // R4
  AST_LOW_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    (active_i && !lvl_i) |-> (lcnt_q < n_i - hi_i)); // R4
endmodule

bind phase_clk_div phase_clk_div_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .sync_i(sync_i), .start_i(start),
  .lvl_i(lvl_q), .active_i(active), .n_i(cfg_n), .hi_i(cfg_hi)
);

// File: tb/phase_clk_div_bench.sv
module phase_clk_div_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       sync;
  logic [3:0] ratio_m1;
  logic [3:0] ph_a;
  logic [3:0] ph_b;
  logic       div_a;
  logic       div_b;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  typedef struct {
    logic  a;
    logic  b;
    logic  byp;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;

  always #10 clk = ~clk;

  phase_clk_div u_phase_clk_div (
    .clk_i(clk), .rst_i(rst), .sync_i(sync),
    .ratio_m1_i(ratio_m1), .phase_i(ph_a), .div_o(div_a)
  );

  phase_clk_div u_phase_clk_div_b (
    .clk_i(clk), .rst_i(rst), .sync_i(sync),
    .ratio_m1_i(ratio_m1), .phase_i(ph_b), .div_o(div_b)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Level in cycle c after the load edge: first high on edge 1+k, then N-cycle pattern.
  function automatic logic exp_lvl(int c, int n, int p);
    int k = p % n;
    if (c < 1 + k) return 1'b0;
    return ((c - 1 - k) % n) < ((n + 1) / 2);
  endfunction

  task automatic run_case(int n, int pa, int pb, int cycles, string tag);
    @(negedge clk);
    sync = 1'b1;
    ratio_m1 = 4'(n - 1);
    ph_a = 4'(pa);
    ph_b = 4'(pb);
    for (int i = 0; i < 3; i++) q.push_back('{1'b0, 1'b0, 1'b0, "R2"});
    repeat (3) @(negedge clk);
    sync = 1'b0;
    for (int c = 0; c < cycles; c++)
      q.push_back('{exp_lvl(c, n, pa), exp_lvl(c, n, pb), (n == 1),
                    (c >= cycles / 2) ? "R8" : tag});
    repeat (cycles / 2) @(negedge clk);
    // Disturb the settings mid-run; the waveform must not change (R8).
    ratio_m1 = 4'(n + 2);
    ph_a = 4'(pb + 3);
    ph_b = 4'(pa + 5);
    repeat (cycles - cycles / 2) @(negedge clk);
  endtask

  // Monitor: a quarter period into the high half and into the low half of each cycle.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        cur = q[0];
        chk(cur.tag, "A high-half", div_a, cur.a);
        chk(cur.tag, "B high-half", div_b, cur.b);
        #10;
        chk(cur.tag, "A low-half", div_a, cur.a & ~cur.byp);
        chk(cur.tag, "B low-half", div_b, cur.b & ~cur.byp);
        void'(q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    sync = 1'b0;
    ratio_m1 = 4'd3;
    ph_a = 4'd0;
    ph_b = 4'd1;
    repeat (3) @(negedge clk);
    chk("R1", "A in reset", div_a, 1'b0);
    chk("R1", "B in reset", div_b, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R1", "A before sync", div_a, 1'b0);
      chk("R1", "B before sync", div_b, 1'b0);
    end
    run_case(4, 0, 3, 32, "R3");
    run_case(4, 1, 4, 32, "R5");
    run_case(9, 0, 8, 48, "R6");
    run_case(9, 15, 2, 48, "R5");
    run_case(16, 15, 0, 64, "R4");
    run_case(2, 1, 0, 24, "R4");
    run_case(5, 3, 7, 40, "R6");
    run_case(1, 7, 0, 16, "R7");
    run_case(3, 2, 1, 30, "R3");
    run_case(7, 6, 0, 40, "R3");
    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule